// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the internal RAM address for one port of a synchronous memory. At every rising clock edge it does one of four things. It can clear the address to zero, take a new address from outside, step the address up by one, or keep the address it already holds. The result is registered. That register value is the address that the access of the current cycle uses, so a reset, a load or an advance never costs a dead cycle.

All three controls are active low and are sampled on the clock edge. They follow a fixed priority: counter clear first, then external load, then advance. The controls act whether or not the port is selected. The block also registers the port select, taken from a pair of chip enables, so that the access logic receives the select in step with the address. When an advance steps past the top address, the address wraps to zero and a single-cycle wrap flag is raised.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0, sel_o is 0 and wrap_o is 0. These values hold after rst_ni is released until the next clock edge.
- R2: If cnt_rst_ni is 0 at a rising edge, addr_o becomes 0 after that edge, whatever ads_ni, cnt_en_ni and ext_addr_i are.
- R3: If cnt_rst_ni is 1 and ads_ni is 0 at a rising edge, addr_o becomes ext_addr_i after that edge, whatever cnt_en_ni is.
- R4: If cnt_rst_ni is 1, ads_ni is 1 and cnt_en_ni is 0 at a rising edge, addr_o becomes its previous value plus one.
- R5: If cnt_rst_ni, ads_ni and cnt_en_ni are all 1 at a rising edge, addr_o keeps its value.
- R6: The clear, load and advance of R2 to R4 act in the same way whatever the values of ce0_ni and ce1_i.
- R7: An advance from the all-ones address (32767 at the default 15-bit width) gives addr_o = 0. In the cycle that follows, and only in that cycle, wrap_o is 1. A clear or a load never sets wrap_o.
- R8: After each rising edge, sel_o equals the value of (ce0_ni == 0 and ce1_i == 1) sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | ADDR_W (15) | External address, loaded when the strobe is low |
| ads_ni | input | 1 | Address strobe, active low |
| cnt_en_ni | input | 1 | Counter advance enable, active low |
| cnt_rst_ni | input | 1 | Counter clear, active low |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| addr_o | output | ADDR_W (15) | Address used by the access in the current cycle |
| sel_o | output | 1 | Registered port select for the current cycle |
| wrap_o | output | 1 | One-cycle flag after an advance wraps to zero |

## Verification
The bench drives controls that conflict with each other. A clear together with a low strobe must give zero; a design with the wrong priority would load the external value instead. A load together with an advance must take the external value and must not add one to it.

Other vectors advance, clear and load while the port is deselected. A design that gated the counter with the chip enables would hold its old address there.

The bench also advances from the all-ones address. A design that saturated, or that flagged the wrap on the wrong cycle, would show a non-zero address or a wrap flag that is misplaced or stays high. A clear and a load made from the all-ones address must leave the wrap flag low.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_ADV   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic     ads_ni,
  input  logic     cnt_en_ni,
  input  logic     cnt_rst_ni,
  output addr_op_e op_o
);
  // fixed priority: clear > load > advance > hold
  always_comb begin
    if (!cnt_rst_ni)     op_o = OP_CLEAR;
    else if (!ads_ni)    op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_ADV;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_addr_cnt.sv
module burst_addr_cnt
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  addr_op_e          op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wrap_q, wrap_d;

  always_comb begin
    addr_d = addr_q;
    wrap_d = 1'b0;
    unique case (op_i)
      OP_CLEAR: addr_d = '0;
      OP_LOAD:  addr_d = ext_addr_i;
      OP_ADV: begin
        addr_d = addr_q + 1'b1;
        wrap_d = (addr_q == TOP_ADDR);
      end
      default:  addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wrap_q <= wrap_d;
    end
  end

  assign addr_o = addr_q;
  assign wrap_o = wrap_q;

  // R7
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (addr_o == '0));
  // R7
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/burst_addr_sel.sv
module burst_addr_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce0_ni,
  input  logic ce1_i,
  output logic sel_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= !ce0_ni && ce1_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              ads_ni,
  input  logic              cnt_en_ni,
  input  logic              cnt_rst_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  addr_op_e op;

  burst_addr_ctrl u_ctrl (
    .ads_ni     (ads_ni),
    .cnt_en_ni  (cnt_en_ni),
    .cnt_rst_ni (cnt_rst_ni),
    .op_o       (op)
  );

  burst_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .ext_addr_i (ext_addr_i),
    .addr_o     (addr_o),
    .wrap_o     (wrap_o)
  );

  // select is registered apart from the counter; it never gates the counter
  burst_addr_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce0_ni (ce0_ni),
    .ce1_i  (ce1_i),
    .sel_o  (sel_o)
  );

  // R2
  clear_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_rst_ni |=> (addr_o == '0));
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && !ads_ni) |=> (addr_o == $past(ext_addr_i)));
  // R4
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && !cnt_en_ni) |=> (addr_o == $past(addr_o) + 1'b1));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && cnt_en_ni) |=> $stable(addr_o));
  // R7
  wrap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && ads_ni && !cnt_en_ni && addr_o == TOP_ADDR) |=> wrap_o);
  // R8
  sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce0_ni && ce1_i) |=> sel_o);
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 15;

  typedef struct packed {
    logic          crst_n;
    logic          ads_n;
    logic          cen_n;
    logic          ce0_n;
    logic          ce1;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp_addr;
    logic          exp_sel;
    logic          exp_wrap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'd100,   15'd100,   1'b1, 1'b0}, // R3 load
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 15'd9,     15'd101,   1'b1, 1'b0}, // R4 advance
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 15'd0,     15'd102,   1'b0, 1'b0}, // R6 advance deselected
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 15'd500,   15'd102,   1'b1, 1'b0}, // R5 hold
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 15'd7,     15'd7,     1'b1, 1'b0}, // R3 load beats advance
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 15'd55,    15'd0,     1'b1, 1'b0}, // R2 clear beats load
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'd3,     15'd0,     1'b0, 1'b0}, // R6 clear deselected
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 15'd32766, 15'd32766, 1'b0, 1'b0}, // R6 load deselected
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 15'd0,     15'd32767, 1'b1, 1'b0}, // R4 to top
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 15'd0,     15'd0,     1'b1, 1'b1}, // R7 wrap
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 15'd0,     15'd0,     1'b1, 1'b0}, // R7 flag drops
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'd0,     15'd1,     1'b0, 1'b0}  // R8 sel low
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          ads_ni = 1'b1, cnt_en_ni = 1'b1, cnt_rst_ni = 1'b1;
  logic          ce0_ni = 1'b1, ce1_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          sel_o, wrap_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk_i, .rst_ni, .ext_addr_i, .ads_ni, .cnt_en_ni, .cnt_rst_ni,
    .ce0_ni, .ce1_i, .addr_o, .sel_o, .wrap_o
  );

  task automatic check(string req, logic [AW-1:0] ea, logic es, logic ew);
    n_run++;
    if (addr_o !== ea || sel_o !== es || wrap_o !== ew) begin
      n_fail++;
      $display("FAIL %s: addr=%0d sel=%b wrap=%b expected addr=%0d sel=%b wrap=%b",
               req, addr_o, sel_o, wrap_o, ea, es, ew);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk_i);
    cnt_rst_ni = v.crst_n; ads_ni = v.ads_n; cnt_en_ni = v.cen_n;
    ce0_ni = v.ce0_n; ce1_i = v.ce1; ext_addr_i = v.ext;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check("R1", '0, 1'b0, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    #0.5 check("R1", '0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("vec%0d", i), VEC[i].exp_addr, VEC[i].exp_sel, VEC[i].exp_wrap);
    end

    // R7: a load to top followed by a clear must not flag a wrap
    drive('{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'd32767, 15'd32767, 1'b1, 1'b0});
    check("R3", 15'd32767, 1'b1, 1'b0);
    drive('{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 15'd0, 15'd0, 1'b1, 1'b0});
    check("R7", 15'd0, 1'b1, 1'b0);
    // R7: a load from top must not flag a wrap
    drive('{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'd32767, 15'd32767, 1'b1, 1'b0});
    drive('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 15'd0, 15'd0, 1'b1, 1'b0});
    check("R7", 15'd0, 1'b1, 1'b0);
    // R6: wrap while deselected
    drive('{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 15'd32767, 15'd32767, 1'b0, 1'b0});
    drive('{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'd0, 15'd0, 1'b0, 1'b1});
    check("R6", 15'd0, 1'b0, 1'b1);
    // R1: async reset mid-run
    drive('{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'd1234, 15'd1234, 1'b1, 1'b0});
    check("R3", 15'd1234, 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5 check("R1", '0, 1'b0, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule